// File: doc/BRIEF.md
# Per-Half Bus Inversion Codec

This block sits on a 32-bit source-synchronous data path and lowers the number of lines that switch from one transfer to the next. The transmit half looks at every outgoing word as two 16-bit groups. It compares each group with the value it last drove on the wires. When driving the group as it is would make more than eight of its seventeen lines switch, it drives the complement instead. The seventeen lines are the sixteen data wires and the group's own inversion flag. The receive half uses the two flag wires to undo the complement as it captures a word. Each direction registers its result, so each has one cycle of latency.

Inversion is switched on only by the high-speed mode input. In the slow modes the words pass through unchanged, the flags read 0, and the transmit history is held at zero. Entering the high-speed mode therefore always starts the comparison from an all-zero history. The flag wire of the upper group can instead carry a pipelined-request bit, chosen by a configuration input. When that choice is made, the upper group is never inverted. The receiver then ignores that wire for data and passes it out as a request.

Top module: `dbi_codec`

## Requirements
- R1: While reset is low at a clock edge, every output is 0 after that edge: `tx_bus`, `tx_inv`, `rx_data`, `rx_data_valid` and `rx_req`.
- R2: With `fast_mode` low, a word accepted on `tx_valid` appears unchanged on `tx_bus` one cycle later, and both flag bits are 0.
- R3: With `fast_mode` high, each group is inverted when its count exceeds 8. The count is the number of data bits that differ from that group's history plus 1 when the group's last flag was 1. An inverted group is driven as the complement, with its flag bit set to 1. Flag bit 1 belongs to bits 31:16 and flag bit 0 belongs to bits 15:0.
- R4: Between two accepted high-speed transfers, at most 8 of each encoded group's 17 lines (16 data wires and its flag) change.
- R5: The two groups decide independently; the content of one group never changes how the other is encoded.
- R6: With `tx_valid` low, `tx_bus`, the flags and the history keep their values.
- R7: After `fast_mode` has been low for at least one clock, the first high-speed word is compared against an all-zero history with both flags at 0.
- R8: With `share_req` high, `tx_inv[1]` carries `tx_req` delayed by one cycle, and bits 31:16 are never inverted. The encoding of bits 15:0 is unaffected.
- R9: With `fast_mode` high, a word accepted on `rx_valid` appears on `rx_data` one cycle later. Each group is XORed with its own flag bit repeated 16 times. `rx_data_valid` equals `rx_valid` delayed by one cycle.
- R10: With `fast_mode` low, the receive flags are ignored and `rx_data` equals the captured `rx_bus`.
- R11: With `share_req` high, `rx_inv[1]` does not affect bits 31:16 of `rx_data`, and `rx_req` equals that wire delayed by one cycle. `rx_req` is 0 otherwise.
- R12: With `rx_valid` low, `rx_data` keeps its value.
- R13: When `tx_bus`/`tx_inv` are fed back into `rx_bus`/`rx_inv` in high-speed mode, `rx_data` reproduces each transmitted word two cycles after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_mode | input | 1 | High-speed transfer mode; enables inversion |
| share_req | input | 1 | Upper flag wire carries the request bit instead of a flag |
| tx_valid | input | 1 | A transmit word is presented this cycle |
| tx_data | input | 32 | Word to transmit |
| tx_req | input | 1 | Request bit for the shared wire |
| tx_bus | output | 32 | Encoded data wires |
| tx_inv | output | 2 | Flag wires: bit 1 for 31:16, bit 0 for 15:0 |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_bus | input | 32 | Received data wires |
| rx_inv | input | 2 | Received flag wires |
| rx_data_valid | output | 1 | Decoded word valid |
| rx_data | output | 32 | Decoded word |
| rx_req | output | 1 | Received request bit |

## Verification
Two functions can land in the same cycle. In one cycle the upper group may cross the inversion threshold while the shared wire has been assigned to the request function. The bench provokes this by running random high-speed traffic with `share_req` set and `tx_req` toggling at random. It then checks that `tx_inv[1]` follows the request and that bits 31:16 are driven raw, while the lower group still follows its own threshold. The same collision is checked on the receive side by driving random upper flag values while sharing is on.

// File: rtl/dbi_pkg.sv
// Shared sizing defaults for the bus inversion codec.
// Assumes the data width is a whole multiple of the group width.
package dbi_pkg;
    localparam int DBI_DATA_W = 32;
    localparam int DBI_GRP_W  = 16;

    // Switching budget for one group: half of its data lines.
    function automatic int toggle_budget(input int grp_w);
        return grp_w / 2;
    endfunction
endpackage

// File: rtl/dbi_grp_enc.sv
// One group's inversion decision (combinational).
// Counts the data lines that differ from the history plus the previous
// flag. Drives the complement when that count exceeds LIMIT and en is high.
// Assumes hist/hflag are the values last driven on the wires.
module dbi_grp_enc #(
    parameter int GRP_W = 16,
    parameter int LIMIT = GRP_W / 2
) (
    input  logic             en,
    input  logic [GRP_W-1:0] din,
    input  logic [GRP_W-1:0] hist,
    input  logic             hflag,
    output logic [GRP_W-1:0] dout,
    output logic             inv
);
    localparam int CW = $clog2(GRP_W + 2);

    logic [CW-1:0] cnt;

    // Count the lines that would switch if the group were sent as is.
    always_comb begin
        cnt = CW'(hflag);
        for (int i = 0; i < GRP_W; i++) begin
            cnt = cnt + CW'(din[i] ^ hist[i]);
        end
    end

    assign inv  = en && (cnt > CW'(LIMIT));
    assign dout = inv ? ~din : din;
endmodule

// File: rtl/dbi_tx.sv
// Transmit encoder: one decision per group, registered bus and flags,
// and per-group history that the next decision is measured against.
// Assumes fast_mode and share_req are quasi-static configuration.
// The history and flags are cleared whenever fast_mode is low.
module dbi_tx #(
    parameter int DATA_W     = 32,
    parameter int GRP_W      = 16,
    parameter int SHARED_GRP = DATA_W / GRP_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fast_mode,
    input  logic                      share_req,
    input  logic                      tx_valid,
    input  logic [DATA_W-1:0]         tx_data,
    input  logic                      tx_req,
    output logic [DATA_W-1:0]         bus_q,
    output logic [DATA_W/GRP_W-1:0]   flag_q,
    output logic                      req_q
);
    localparam int NGRP  = DATA_W / GRP_W;
    localparam int LIMIT = dbi_pkg::toggle_budget(GRP_W);

    logic [DATA_W-1:0] hist_q;
    logic [DATA_W-1:0] enc_data;
    logic [NGRP-1:0]   enc_inv;
    logic [NGRP-1:0]   grp_en;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // The shared group is never inverted when its flag wire is lent out.
        assign grp_en[g] = fast_mode && !(share_req && (g == SHARED_GRP));

        dbi_grp_enc #(
            .GRP_W(GRP_W),
            .LIMIT(LIMIT)
        ) u_enc (
            .en   (grp_en[g]),
            .din  (tx_data[g*GRP_W +: GRP_W]),
            .hist (hist_q[g*GRP_W +: GRP_W]),
            .hflag(flag_q[g]),
            .dout (enc_data[g*GRP_W +: GRP_W]),
            .inv  (enc_inv[g])
        );

        // R4
        toggle_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && grp_en[g]) |=>
            (int'($countones(bus_q[g*GRP_W +: GRP_W] ^ $past(hist_q[g*GRP_W +: GRP_W])))
             + int'(flag_q[g] != $past(flag_q[g]))) <= LIMIT);
    end

    // Drive the wires and advance the history on accepted transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q  <= '0;
            flag_q <= '0;
            hist_q <= '0;
        end else begin
            if (tx_valid) begin
                bus_q <= enc_data;
            end
            if (!fast_mode) begin
                hist_q <= '0;
                flag_q <= '0;
            end else if (tx_valid) begin
                hist_q <= enc_data;
                flag_q <= enc_inv;
            end
        end
    end

    // Register the request bit every cycle for the shared flag wire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= tx_req;
        end
    end

    // R2
    slow_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !fast_mode) |=> (bus_q == $past(tx_data)) && (flag_q == '0));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> $stable(bus_q));
endmodule

// File: rtl/dbi_rx.sv
// Receive decoder: undoes each group's inversion when the word is captured
// and registers the result. Flags count only in fast_mode. The shared flag
// wire is routed to req_q instead when share_req is high.
// Assumes the flag wires are aligned with the data wires.
module dbi_rx #(
    parameter int DATA_W     = 32,
    parameter int GRP_W      = 16,
    parameter int SHARED_GRP = DATA_W / GRP_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fast_mode,
    input  logic                      share_req,
    input  logic                      rx_valid,
    input  logic [DATA_W-1:0]         rx_bus,
    input  logic [DATA_W/GRP_W-1:0]   rx_inv,
    output logic [DATA_W-1:0]         data_q,
    output logic                      dv_q,
    output logic                      req_q
);
    localparam int NGRP = DATA_W / GRP_W;

    logic [NGRP-1:0]   flag_eff;
    logic [DATA_W-1:0] dec;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // A flag counts only in fast mode and when its wire is not lent out.
        assign flag_eff[g] = rx_inv[g] && fast_mode && !(share_req && (g == SHARED_GRP));
        assign dec[g*GRP_W +: GRP_W] = rx_bus[g*GRP_W +: GRP_W] ^ {GRP_W{flag_eff[g]}};
    end

    // Capture the decoded word and its valid marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dv_q   <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            dv_q  <= rx_valid;
            req_q <= share_req ? rx_inv[SHARED_GRP] : 1'b0;
            if (rx_valid) begin
                data_q <= dec;
            end
        end
    end

    // R12
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(data_q));

    // R9
    rx_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dv_q);

    // R10
    rx_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !fast_mode) |=> (data_q == $past(rx_bus)));
endmodule

// File: rtl/dbi_codec.sv
// Top of the bus inversion codec: transmit encoder, receive decoder and
// the shared upper flag wire mux. Both directions have one cycle latency.
// Assumes a single clock for both directions.
module dbi_codec #(
    parameter int DATA_W = dbi_pkg::DBI_DATA_W,
    parameter int GRP_W  = dbi_pkg::DBI_GRP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fast_mode,
    input  logic                    share_req,
    input  logic                    tx_valid,
    input  logic [DATA_W-1:0]       tx_data,
    input  logic                    tx_req,
    output logic [DATA_W-1:0]       tx_bus,
    output logic [DATA_W/GRP_W-1:0] tx_inv,
    input  logic                    rx_valid,
    input  logic [DATA_W-1:0]       rx_bus,
    input  logic [DATA_W/GRP_W-1:0] rx_inv,
    output logic                    rx_data_valid,
    output logic [DATA_W-1:0]       rx_data,
    output logic                    rx_req
);
    localparam int NGRP       = DATA_W / GRP_W;
    localparam int SHARED_GRP = NGRP - 1;

    logic [NGRP-1:0] tx_flag;
    logic            tx_req_q;

    dbi_tx #(
        .DATA_W    (DATA_W),
        .GRP_W     (GRP_W),
        .SHARED_GRP(SHARED_GRP)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_mode(fast_mode),
        .share_req(share_req),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_req   (tx_req),
        .bus_q    (tx_bus),
        .flag_q   (tx_flag),
        .req_q    (tx_req_q)
    );

    dbi_rx #(
        .DATA_W    (DATA_W),
        .GRP_W     (GRP_W),
        .SHARED_GRP(SHARED_GRP)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_mode(fast_mode),
        .share_req(share_req),
        .rx_valid (rx_valid),
        .rx_bus   (rx_bus),
        .rx_inv   (rx_inv),
        .data_q   (rx_data),
        .dv_q     (rx_data_valid),
        .req_q    (rx_req)
    );

    // Route flags to the wires; the shared wire may carry the request bit.
    for (genvar g = 0; g < NGRP; g++) begin : g_pin
        if (g == SHARED_GRP) begin : g_shared
            assign tx_inv[g] = share_req ? tx_req_q : tx_flag[g];
        end else begin : g_plain
            assign tx_inv[g] = tx_flag[g];
        end
    end

    // R8
    req_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (share_req && $past(share_req) && $past(rst_n)) |->
        (tx_inv[SHARED_GRP] == $past(tx_req)));

    // R8
    shared_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (share_req && tx_valid) |=>
        (tx_bus[SHARED_GRP*GRP_W +: GRP_W] == $past(tx_data[SHARED_GRP*GRP_W +: GRP_W])));
endmodule

// File: tb/dbi_codec_bench.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared each cycle against a behavioural model built from the requirements.
module dbi_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_mode = 1'b0, share_req = 1'b0;
    logic        tx_valid = 1'b0, tx_req = 1'b0;
    logic [31:0] tx_data = '0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_bus = '0;
    logic [1:0]  rx_inv = '0;
    logic [31:0] tx_bus, rx_data;
    logic [1:0]  tx_inv;
    logic        rx_data_valid, rx_req;

    int total = 0, bad = 0;
    bit chk_on = 0, lb_on = 0, done = 0;
    string ph_tx = "R3";

    // model state
    logic [31:0] m_bus, m_hist, m_rxd, pre_hist, lb_d1, lb_d2;
    logic [1:0]  m_flag, pre_flag;
    logic        m_txreq, m_rxdv, m_rxreq;
    bit          p_valid, p_fast, p_share, p_rxv, r4_pend;
    int          lb_cnt;

    dbi_codec u_dbi_codec (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .share_req(share_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_req(tx_req),
        .tx_bus(tx_bus), .tx_inv(tx_inv),
        .rx_valid(rx_valid), .rx_bus(rx_bus), .rx_inv(rx_inv),
        .rx_data_valid(rx_data_valid), .rx_data(rx_data), .rx_req(rx_req)
    );

    always #2 clk = ~clk;

    function automatic int pop16(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each edge, comparison 1 ns later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bus = '0; m_flag = '0; m_hist = '0; m_txreq = 0;
            m_rxd = '0; m_rxdv = 0; m_rxreq = 0; r4_pend = 0; lb_cnt = 0;
        end else begin
            p_valid = tx_valid; p_fast = fast_mode; p_share = share_req; p_rxv = rx_valid;
            r4_pend = tx_valid && fast_mode;
            pre_hist = m_hist; pre_flag = m_flag;
            m_txreq = tx_req;
            for (int g = 0; g < 2; g++) begin
                logic [15:0] dg, eg;
                bit en, inv;
                int cnt;
                en  = fast_mode && !(share_req && g == 1);
                dg  = tx_data[g*16 +: 16];
                cnt = pop16(dg ^ m_hist[g*16 +: 16]) + int'(m_flag[g]);
                inv = en && (cnt > 8);
                eg  = inv ? ~dg : dg;
                if (tx_valid) m_bus[g*16 +: 16] = eg;
                if (!fast_mode) begin
                    m_hist[g*16 +: 16] = '0; m_flag[g] = 1'b0;
                end else if (tx_valid) begin
                    m_hist[g*16 +: 16] = eg; m_flag[g] = inv;
                end
            end
            m_rxdv = rx_valid;
            if (rx_valid) begin
                for (int g = 0; g < 2; g++) begin
                    bit fe;
                    fe = rx_inv[g] && fast_mode && !(share_req && g == 1);
                    m_rxd[g*16 +: 16] = rx_bus[g*16 +: 16] ^ {16{fe}};
                end
            end
            m_rxreq = share_req ? rx_inv[1] : 1'b0;
            if (lb_on) begin
                lb_d2 = lb_d1; lb_d1 = tx_data; lb_cnt++;
            end else lb_cnt = 0;
        end
        #1;
        if (rst_n && chk_on) begin
            string tt, rt;
            logic [1:0] exp_inv;
            tt = !p_valid ? "R6" : !p_fast ? "R2" : p_share ? "R8" : ph_tx;
            rt = !p_rxv ? "R12" : !p_fast ? "R10" : p_share ? "R11" : "R9";
            exp_inv = {p_share ? m_txreq : m_flag[1], m_flag[0]};
            check(tx_bus == m_bus, tt, 64'(tx_bus), 64'(m_bus));
            check(tx_inv == exp_inv, tt, 64'(tx_inv), 64'(exp_inv));
            check(rx_data == m_rxd, rt, 64'(rx_data), 64'(m_rxd));
            check(rx_data_valid == m_rxdv, "R9", 64'(rx_data_valid), 64'(m_rxdv));
            check(rx_req == m_rxreq, "R11", 64'(rx_req), 64'(m_rxreq));
            if (r4_pend) begin
                for (int g = 0; g < 2; g++) begin
                    if (!(p_share && g == 1)) begin
                        int tog;
                        tog = pop16(tx_bus[g*16 +: 16] ^ pre_hist[g*16 +: 16])
                            + int'(tx_inv[g] != pre_flag[g]);
                        check(tog <= 8, "R4", 64'(tog), 64'd8);
                    end
                end
            end
            if (lb_cnt >= 2)
                check(rx_data == lb_d2, "R13", 64'(rx_data), 64'(lb_d2));
        end
    end

    task automatic cyc(input logic v, input logic [31:0] d);
        @(negedge clk);
        tx_valid = v; tx_data = d; tx_req = 1'($urandom);
        if (lb_on) begin
            rx_valid = 1'b1; rx_bus = tx_bus; rx_inv = tx_inv;
        end else begin
            rx_valid = 1'($urandom); rx_bus = $urandom; rx_inv = 2'($urandom);
        end
    endtask

    // Random words: half fully random, half a few bit flips from the last.
    task automatic rnd(input int n);
        logic [31:0] d;
        for (int k = 0; k < n; k++) begin
            d = tx_data;
            if ($urandom_range(1, 0) == 1) d = $urandom;
            else for (int j = 0; j < int'($urandom_range(10, 5)); j++) d[$urandom_range(31, 0)] ^= 1'b1;
            cyc(($urandom_range(7, 0) != 0), d);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(tx_bus == '0 && tx_inv == '0, "R1", {tx_bus, 30'd0, tx_inv}, 64'd0);
        check(rx_data == '0 && !rx_data_valid && !rx_req, "R1", 64'(rx_data), 64'd0);
        @(negedge clk); rst_n = 1'b1; chk_on = 1;
        // R2: slow mode pass-through
        rnd(20);
        // R7: entering fast mode from cleared history, all-ones word inverts both
        @(negedge clk); fast_mode = 1'b1; tx_valid = 1'b0;
        ph_tx = "R7";
        cyc(1'b1, 32'hFFFF_FFFF);
        // R3: thresholds with flags at 1: low 7+1=8 keeps, high 8+1=9 inverts
        ph_tx = "R3";
        cyc(1'b1, 32'h00FF_007F);
        // R5: groups independent
        ph_tx = "R5";
        cyc(1'b1, 32'h0000_FFFF);
        cyc(1'b1, 32'hFFFF_0000);
        cyc(1'b1, 32'h5555_5555);
        // R6: valid low, data moving
        cyc(1'b0, 32'h1234_5678);
        cyc(1'b0, 32'hDEAD_BEEF);
        ph_tx = "R3";
        rnd(300);
        // R7: leave and re-enter fast mode
        @(negedge clk); fast_mode = 1'b0;
        rnd(5);
        @(negedge clk); fast_mode = 1'b1;
        ph_tx = "R7";
        cyc(1'b1, 32'hFF80_01FF);
        ph_tx = "R3";
        rnd(100);
        // R8, R11: shared wire carries the request
        @(negedge clk); share_req = 1'b1;
        cyc(1'b1, 32'hFFFF_FFFF);
        rnd(200);
        @(negedge clk); fast_mode = 1'b0;
        rnd(30);
        @(negedge clk); share_req = 1'b0; fast_mode = 1'b1;
        // R13: loopback
        @(negedge clk); lb_on = 1;
        ph_tx = "R3";
        for (int k = 0; k < 150; k++) cyc(1'b1, (k % 3 == 0) ? ~tx_data : $urandom);
        @(negedge clk); lb_on = 0;
        rnd(50);
        @(negedge clk); chk_on = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule